// File: doc/BRIEF.md
# E3 Serial Transmit Payload Framer

This block sits between system-side equipment and an E3 transmit path. It runs from a single transmit bit clock, which is also the clock the system side uses in loop-timing operation. It cuts the bit stream into 1536-bit frames. Each frame opens with 12 overhead positions, then 1524 payload positions. During the overhead positions the block asserts an overhead indicator and inserts a fixed 10-bit alignment word, an alarm bit and a national bit. During the payload positions it forwards the system's serial data. A one-cycle frame strobe marks the first position of every frame.

The system side samples the overhead indicator on every rising clock edge and holds its next payload bit while the indicator is high. Any data it presents during overhead positions is discarded, so no gapped clock is needed. Framing runs only when the enable input is high, the interface-width select is low (serial) and the two-bit timing reference select equals 00 (loop timing). That combined condition is called "go" below. When go is low, all outputs are held low.

The sequencer has three states:
- IDLE, with the transition START to OVHD when go is seen.
- OVHD, with the transition OH_DONE to PAYLD after position 11.
- PAYLD, with the transition WRAP back to OVHD after position 1535.
- From any state, the transition HALT returns to IDLE whenever go is low at a clock edge.

Top module: `e3tx_payload_if`

## Requirements
- R1: `oh_ind` is high for exactly 12 consecutive cycles in each 1536-cycle frame, starting in the frame's first cycle (position 0), and is low in positions 12 to 1535.
- R2: `frame_strobe` is high for exactly one cycle per frame, in position 0, so strobes are 1536 cycles apart while framing runs.
- R3: `line_out` carries the bit of position p in the cycle after position p. Positions 0 to 9 carry the alignment word 1,1,1,1,0,1,0,0,0,0, with position 0 first.
- R4: Position 10 carries `alarm_bit` and position 11 carries `national_bit`, each as sampled at the clock edge that ends that position.
- R5: Positions 12 to 1535 (payload indices 0 to 1523) carry `sys_data` as sampled at the clock edge that ends that position. The bit after payload index 1523 is alignment bit 1 of the next frame.
- R6: The value on `sys_data` during positions 0 to 11 has no effect on `line_out`.
- R7: Framing starts only when go is high, where go means `enable`=1, `nib_mode`=0 and `tref_sel`=2'b00. The first position 0 is the cycle after the first edge at which go is sampled high, and `line_out` is 0 in that cycle.
- R8: After any clock edge at which go is sampled low, `frame_strobe`, `oh_ind` and `line_out` are all 0. A later restart begins again at position 0.
- R9: While reset is asserted and just after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Framing enable |
| nib_mode | input | 1 | Interface-width select; 0 selects serial |
| tref_sel | input | 2 | Timing reference select; 00 selects loop timing |
| alarm_bit | input | 1 | Value inserted at overhead position 10 |
| national_bit | input | 1 | Value inserted at overhead position 11 |
| sys_data | input | 1 | Serial payload bit from system side |
| frame_strobe | output | 1 | One-cycle frame boundary marker |
| oh_ind | output | 1 | High during the 12 overhead positions |
| line_out | output | 1 | Assembled serial line stream |

## Verification
The frame wrap is the busy cycle. In the cycle where `frame_strobe` and the rise of `oh_ind` appear for the new frame, `line_out` still carries payload index 1523 of the old frame. All three are provoked together by running several back-to-back frames with random payload, and each is judged separately against a scoreboard queue of expected line bits. A second collision is provoked by dropping go in the middle of overhead and in the middle of payload. The bench then checks that the outputs clear on the very next cycle and that the restart produces a fresh strobe rather than resuming the old count.

// File: rtl/e3tx_pkg.sv
package e3tx_pkg;
    localparam int          DEF_FRAME_BITS = 1536;
    localparam int          DEF_OH_BITS    = 12;
    localparam int          DEF_FAW_LEN    = 10;
    localparam logic [9:0]  DEF_FAW_WORD   = 10'b1111010000;
    localparam int          DEF_TREF_W     = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OVHD  = 2'd1,
        ST_PAYLD = 2'd2
    } e3tx_state_t;
endpackage

// File: rtl/e3tx_mode_chk.sv
module e3tx_mode_chk #(
    parameter int              TREF_W   = 2,
    parameter logic [TREF_W-1:0] LOOP_SEL = '0
) (
    input  logic              enable,
    input  logic              nib_mode,
    input  logic [TREF_W-1:0] tref_sel,
    output logic              go
);
    always_comb begin
        go = enable && !nib_mode && (tref_sel == LOOP_SEL);
    end
endmodule

// File: rtl/e3tx_seq.sv
module e3tx_seq
    import e3tx_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int OH_BITS    = 12,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output e3tx_state_t      state,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_OH  = CNT_W'(OH_BITS - 1);

    e3tx_state_t      nxt_state;
    logic [CNT_W-1:0] nxt_pos;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
        end else begin
            state <= nxt_state;
            pos   <= nxt_pos;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_pos   = pos;
        unique case (state)
            ST_IDLE: begin
                nxt_pos = '0;
                if (go) nxt_state = ST_OVHD;          // START
            end
            ST_OVHD: begin
                if (!go) begin                        // HALT
                    nxt_state = ST_IDLE;
                    nxt_pos   = '0;
                end else begin
                    nxt_pos = pos + 1'b1;
                    if (pos == LAST_OH) nxt_state = ST_PAYLD;  // OH_DONE
                end
            end
            ST_PAYLD: begin
                if (!go) begin                        // HALT
                    nxt_state = ST_IDLE;
                    nxt_pos   = '0;
                end else if (pos == LAST_POS) begin   // WRAP
                    nxt_state = ST_OVHD;
                    nxt_pos   = '0;
                end else begin
                    nxt_pos = pos + 1'b1;
                end
            end
            default: begin
                nxt_state = ST_IDLE;
                nxt_pos   = '0;
            end
        endcase
    end
endmodule

// File: rtl/e3tx_oh_gen.sv
module e3tx_oh_gen #(
    parameter int                 OH_BITS  = 12,
    parameter int                 FAW_LEN  = 10,
    parameter logic [FAW_LEN-1:0] FAW_WORD = 10'b1111010000,
    parameter int                 CNT_W    = 11
) (
    input  logic [CNT_W-1:0] pos,
    input  logic             alarm_bit,
    input  logic             national_bit,
    output logic             oh_bit
);
    logic [OH_BITS-1:0] oh_vec;

    for (genvar i = 0; i < OH_BITS; i++) begin : g_slot
        if (i < FAW_LEN) begin : g_faw
            assign oh_vec[i] = FAW_WORD[FAW_LEN-1-i];
        end else if (i == FAW_LEN) begin : g_alarm
            assign oh_vec[i] = alarm_bit;
        end else if (i == FAW_LEN + 1) begin : g_nat
            assign oh_vec[i] = national_bit;
        end else begin : g_spare
            assign oh_vec[i] = 1'b0;
        end
    end

    always_comb begin
        oh_bit = 1'b0;
        for (int i = 0; i < OH_BITS; i++) begin
            if (pos == CNT_W'(i)) oh_bit = oh_vec[i];
        end
    end
endmodule

// File: rtl/e3tx_payload_if.sv
module e3tx_payload_if
    import e3tx_pkg::*;
#(
    parameter int                 FRAME_BITS = DEF_FRAME_BITS,
    parameter int                 OH_BITS    = DEF_OH_BITS,
    parameter int                 FAW_LEN    = DEF_FAW_LEN,
    parameter logic [FAW_LEN-1:0] FAW_WORD   = DEF_FAW_WORD,
    parameter int                 TREF_W     = DEF_TREF_W,
    parameter logic [TREF_W-1:0]  LOOP_SEL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              nib_mode,
    input  logic [TREF_W-1:0] tref_sel,
    input  logic              alarm_bit,
    input  logic              national_bit,
    input  logic              sys_data,
    output logic              frame_strobe,
    output logic              oh_ind,
    output logic              line_out
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    logic             go;
    e3tx_state_t      state;
    logic [CNT_W-1:0] pos;
    logic             oh_bit;
    logic             line_q;

    e3tx_mode_chk #(.TREF_W(TREF_W), .LOOP_SEL(LOOP_SEL)) u_mode (
        .enable   (enable),
        .nib_mode (nib_mode),
        .tref_sel (tref_sel),
        .go       (go)
    );

    e3tx_seq #(.FRAME_BITS(FRAME_BITS), .OH_BITS(OH_BITS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .state (state),
        .pos   (pos)
    );

    e3tx_oh_gen #(
        .OH_BITS(OH_BITS), .FAW_LEN(FAW_LEN), .FAW_WORD(FAW_WORD), .CNT_W(CNT_W)
    ) u_oh (
        .pos          (pos),
        .alarm_bit    (alarm_bit),
        .national_bit (national_bit),
        .oh_bit       (oh_bit)
    );

    // Line register: bit of the current position, visible next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else if (go && state != ST_IDLE) begin
            line_q <= (state == ST_OVHD) ? oh_bit : sys_data;
        end else begin
            line_q <= 1'b0;
        end
    end

    // Output decode
    always_comb begin
        oh_ind       = 1'b0;
        frame_strobe = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_OVHD: begin
                oh_ind       = 1'b1;
                frame_strobe = (pos == '0);
            end
            ST_PAYLD: ;
            default:  ;
        endcase
        line_out = line_q;
    end
endmodule

// File: rtl/e3tx_chk.sv
module e3tx_chk #(
    parameter int                OH_BITS  = 12,
    parameter int                TREF_W   = 2,
    parameter logic [TREF_W-1:0] LOOP_SEL = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              nib_mode,
    input logic [TREF_W-1:0] tref_sel,
    input logic              frame_strobe,
    input logic              oh_ind,
    input logic              line_out
);
    localparam int RUN_W = $clog2(OH_BITS + 2) + 1;

    logic             go_in;
    logic [RUN_W-1:0] oh_run;

    assign go_in = enable && !nib_mode && (tref_sel == LOOP_SEL);

    always_ff @(posedge clk) begin
        if (!rst_n)      oh_run <= '0;
        else if (oh_ind) oh_run <= (oh_run == '1) ? oh_run : oh_run + 1'b1;
        else             oh_run <= '0;
    end

    AST_OH_MAX_LEN:   assert property (@(posedge clk) disable iff (!rst_n)
        oh_ind |-> (oh_run < RUN_W'(OH_BITS)));                          // R1
    AST_OH_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oh_ind) |-> frame_strobe);                                 // R1
    AST_STROBE_IN_OH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> oh_ind);                                        // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);                                 // R2
    AST_FAW_HEAD:     assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && go_in) |=> line_out);                           // R3
    AST_HALT_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
        !go_in |=> (!oh_ind && !frame_strobe && !line_out));             // R8
endmodule

bind e3tx_payload_if e3tx_chk #(
    .OH_BITS(OH_BITS), .TREF_W(TREF_W), .LOOP_SEL(LOOP_SEL)
) u_chk (.*);

// File: tb/sim_e3tx_payload_if.sv
module sim_e3tx_payload_if;
    localparam int FRAME = 1536;
    localparam int OHB   = 12;
    localparam logic [9:0] FAW = 10'b1111010000;

    typedef struct { logic v; string tag; } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, nib_mode = 1'b0;
    logic [1:0] tref_sel = 2'b00;
    logic alarm_bit = 1'b0, national_bit = 1'b0, sys_data = 1'b0;
    logic frame_strobe, oh_ind, line_out;

    int checks = 0, failures = 0;
    bit done = 0;
    exp_t q[$];
    bit m_run = 0;
    int m_pos = 0;

    always #5 clk = ~clk;

    e3tx_payload_if u0 (.*);

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%0b exp=%0b (pos %0d)", req, what, act, exp, m_pos);
        end
    endtask

    function automatic logic oh_ref(int p);
        if (p < 10) return FAW[9-p];
        if (p == 10) return alarm_bit;
        return national_bit;
    endfunction

    // One bit period: monitor compares, then driver pushes next expectation
    task automatic cycle();
        exp_t e, n;
        bit go;
        chk(m_run ? "R2" : "R7", "frame_strobe", frame_strobe, m_run && m_pos == 0);
        chk(m_run ? "R1" : "R8", "oh_ind", oh_ind, m_run && m_pos < OHB);
        e = q.pop_front();
        chk(e.tag, "line_out", line_out, e.v);
        go = enable && !nib_mode && tref_sel == 2'b00;
        if (m_run && go) begin
            if (m_pos < OHB) begin
                sys_data = ~oh_ref(m_pos);   // must be ignored
                n.v = oh_ref(m_pos);
                n.tag = (m_pos < 10) ? "R3 R6" : "R4 R6";
            end else begin
                sys_data = 1'($urandom);
                n.v = sys_data;
                n.tag = "R5";
            end
        end else begin
            sys_data = 1'($urandom);
            n.v = 1'b0;
            n.tag = m_run ? "R8" : "R7";
        end
        q.push_back(n);
        if (!go) begin m_run = 0; m_pos = 0; end
        else if (!m_run) begin m_run = 1; m_pos = 0; end
        else m_pos = (m_pos + 1) % FRAME;
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            if (m_run && m_pos == 40) begin
                alarm_bit = ~alarm_bit;
                national_bit = $urandom_range(0, 1) == 1;
            end
            cycle();
        end
    endtask

    initial begin
        exp_t z;
        repeat (3) @(negedge clk);
        chk("R9", "frame_strobe", frame_strobe, 1'b0);
        chk("R9", "oh_ind", oh_ind, 1'b0);
        chk("R9", "line_out", line_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        z.v = 1'b0; z.tag = "R9";
        q.push_back(z);
        // invalid mode selects: nothing may start (R7)
        enable = 1'b1; nib_mode = 1'b1; run(6);
        nib_mode = 1'b0; tref_sel = 2'b01; run(6);
        tref_sel = 2'b00; enable = 1'b0; run(4);
        // valid: several back-to-back frames with wrap (R1..R6)
        alarm_bit = 1'b1; national_bit = 1'b0;
        enable = 1'b1; run(3 * FRAME + 50);
        // halt mid-payload, then restart (R8)
        while (m_pos != 700) cycle();
        enable = 1'b0; run(3);
        enable = 1'b1; run(FRAME + 30);
        // halt inside overhead via timing select (R8)
        while (m_pos != 5) cycle();
        tref_sel = 2'b10; run(2);
        tref_sel = 2'b00; run(FRAME + 20);
        enable = 1'b0; run(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired R7");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule